// File: doc/BRIEF.md
# Channel-Routed Mailbox Controller

This block connects a host processor to a set of numbered service channels. It uses two word queues. The inbound queue holds replies waiting for the host. The outbound queue holds requests that could not be delivered because their channel was busy. The host reaches the block through a 32-bit register port with a valid/ready handshake. Only the low eight address bits select a register.

When the host writes a request word, the low four bits of the word name the destination channel. If that channel is idle, the word goes straight to it as a one-cycle strobe. If the channel is busy, the word is parked in the outbound queue. If the outbound queue is full or the channel number does not exist, the word is dropped.

Independently of the host, the block gathers reply words from channels that flag data available. It takes one word per cycle, always from the lowest-numbered available channel, and stops while the inbound queue is full. A single level interrupt tells the host that replies are waiting, subject to an enable bit.

Top module: `chan_mbox_ctrl`

## Requirements
- R1: After reset, both queues are empty, the interrupt is low, and the config register reads 0. Each status register reads 0x4000_0000.
- R2: A read at offsets 0x80, 0x84, 0x88 or 0x8C returns the oldest inbound word and removes it, so words come out in arrival order. When the inbound queue is empty, such a read returns 0xFFFF_FFFF and removes nothing.
- R3: A read at offset 0x90 returns the oldest inbound word without removing it, or 0xFFFF_FFFF when the queue is empty.
- R4: Status words are read at offset 0x98 for the inbound queue and 0xB8 for the outbound queue. Each has bit 31 set when its queue is full, bit 30 set when it is empty, and bits 7:0 holding its word count. All other bits are zero. Address bits above bit 7 are ignored for every register.
- R5: A write at offset 0x9C changes only config bit 0, the interrupt enable, to bit 0 of the written word. A config read returns the enable in bit 0 and the pending flag in bit 4. The pending flag is 1 exactly when the inbound queue is not empty. All other config bits read 0.
- R6: The interrupt output is high exactly when the enable bit and the pending flag are both 1.
- R7: A write at offsets 0xA0 to 0xAC is dropped, with no strobe and no queue change, in two cases: the outbound queue is full, or bits 3:0 of the word are at or above the channel count.
- R8: A write at offsets 0xA0 to 0xAC that is not dropped, and whose channel's busy input is low, raises that channel's request strobe for that one cycle. The request data carries the whole word.
- R9: A write at offsets 0xA0 to 0xAC that is not dropped, and whose channel's busy input is high, raises no strobe. The word goes into the outbound queue instead, and its count rises by one.
- R10: While the inbound queue is not full, the block accepts one reply word per cycle. It pulses the accept strobe of the lowest-numbered channel whose available input is high. While the inbound queue is full, it accepts nothing.
- R11: Reads at offsets with no register return 0. Writes at such offsets, and writes at 0x94, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access request |
| bus_ready | output | 1 | Access accepted; always high, so every access completes in one cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Level interrupt to the host |
| chan_avail | input | NCH | Channel has a reply word ready |
| chan_busy | input | NCH | Channel cannot take a request now |
| chan_rdata | input | NCH*32 | Reply words, channel i in bits 32i+31:32i |
| chan_take | output | NCH | Reply accepted this cycle, one-hot |
| chan_req_data | output | 32 | Request word sent to a channel |
| chan_req_valid | output | NCH | Request strobe, one-hot |

## Verification
The assertions check on every cycle that neither queue is pushed when full or popped when empty. They also check that the accept and request strobes are at most one-hot, that no word is accepted from a channel that is not available, that a config write lands in the enable bit, and that a full outbound queue keeps its count under a write. A word parked for a busy channel is checked to appear at the head of an empty outbound queue. What only the scenarios can show: lowest-channel-first ordering across channels, the stall and resumption of collection around a full inbound queue, the exact values returned by pops, peeks and status words, and that dropped or unsupported accesses leave every port unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [31:0] MBX_EMPTY_MARK = 32'hFFFF_FFFF;
  localparam logic [7:0]  OFF_PEEK       = 8'h90;
  localparam logic [7:0]  OFF_SENDER     = 8'h94;
  localparam logic [7:0]  OFF_IN_STAT    = 8'h98;
  localparam logic [7:0]  OFF_CFG        = 8'h9C;
  localparam logic [7:0]  OFF_OUT_STAT   = 8'hB8;
  localparam int          CFG_EN_BIT     = 0;
  localparam int          CFG_PEND_BIT   = 4;

  function automatic logic [31:0] stat_word(input logic full, input logic empty,
                                            input logic [7:0] cnt);
    return {full, empty, 22'd0, cnt};
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= pdata;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/mbx_collect.sv
module mbx_collect #(
  parameter int NCH  = 9,
  localparam int PKW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] avail,
  input  logic           space,
  output logic [NCH-1:0] take,
  output logic [PKW-1:0] pick,
  output logic           any
);
  always_comb begin
    take = '0;
    pick = '0;
    any  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (space && avail[i] && !any) begin
        take[i] = 1'b1;
        pick    = PKW'(i);
        any     = 1'b1;
      end
    end
  end

  // R10
  take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  // R10
  take_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~avail) == '0);
endmodule

// File: rtl/chan_mbox_ctrl.sv
module chan_mbox_ctrl
  import mbx_pkg::*;
#(
  parameter int NCH    = 9,   // channel count, at most 16
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PKW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  input  logic [NCH-1:0]    chan_avail,
  input  logic [NCH-1:0]    chan_busy,
  input  logic [NCH*32-1:0] chan_rdata,
  output logic [NCH-1:0]    chan_take,
  output logic [31:0]       chan_req_data,
  output logic [NCH-1:0]    chan_req_valid
);
  logic [7:0]     off;
  logic           rd, wr, is_pop, is_send, cfg_we;
  logic           en_q, en_d;
  logic [31:0]    in_head, out_head, pick_word;
  logic [CW-1:0]  in_cnt, out_cnt;
  logic           in_full, in_empty, out_full, out_empty;
  logic           in_pop, coll_any, out_push, fwd;
  logic [PKW-1:0] pick;
  logic [3:0]     ch;
  logic           ch_ok, busy_sel, send_ok;

  assign bus_ready = 1'b1;
  assign off     = bus_addr[7:0];
  assign rd      = bus_valid && !bus_write;
  assign wr      = bus_valid && bus_write;
  assign is_pop  = (off >= 8'h80) && (off <= 8'h8C);
  assign is_send = (off >= 8'hA0) && (off <= 8'hAC);
  assign cfg_we  = wr && (off == OFF_CFG);

  // config enable: next state and register
  always_comb en_d = cfg_we ? bus_wdata[CFG_EN_BIT] : en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (cfg_we) en_q <= en_d;
  end

  assign irq_o = en_q && !in_empty;

  // reply collection into inbound queue
  mbx_collect #(.NCH(NCH)) u_coll (
    .clk(clk), .rst_n(rst_n), .avail(chan_avail), .space(!in_full),
    .take(chan_take), .pick(pick), .any(coll_any)
  );
  assign pick_word = chan_rdata[32*pick +: 32];
  assign in_pop    = rd && is_pop && !in_empty;

  mbx_fifo #(.W(32), .DEPTH(DEPTH)) u_inq (
    .clk(clk), .rst_n(rst_n), .push(coll_any), .pdata(pick_word),
    .pop(in_pop), .head(in_head), .count(in_cnt), .full(in_full), .empty(in_empty)
  );

  // request dispatch
  assign ch    = bus_wdata[3:0];
  assign ch_ok = (32'(ch) < NCH);
  always_comb begin
    busy_sel = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (ch == 4'(i)) busy_sel = chan_busy[i];
  end
  assign send_ok  = wr && is_send && !out_full && ch_ok;
  assign out_push = send_ok && busy_sel;
  assign fwd      = send_ok && !busy_sel;

  always_comb begin
    chan_req_valid = '0;
    for (int i = 0; i < NCH; i++)
      chan_req_valid[i] = fwd && (ch == 4'(i));
  end
  assign chan_req_data = bus_wdata;

  mbx_fifo #(.W(32), .DEPTH(DEPTH)) u_outq (
    .clk(clk), .rst_n(rst_n), .push(out_push), .pdata(bus_wdata),
    .pop(1'b0), .head(out_head), .count(out_cnt), .full(out_full), .empty(out_empty)
  );

  // register read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (is_pop || off == OFF_PEEK)
        bus_rdata = in_empty ? MBX_EMPTY_MARK : in_head;
      else if (off == OFF_IN_STAT)
        bus_rdata = stat_word(in_full, in_empty, 8'(in_cnt));
      else if (off == OFF_OUT_STAT)
        bus_rdata = stat_word(out_full, out_empty, 8'(out_cnt));
      else if (off == OFF_CFG) begin
        bus_rdata[CFG_EN_BIT]   = en_q;
        bus_rdata[CFG_PEND_BIT] = !in_empty;
      end
    end
  end

  // R5
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q == $past(bus_wdata[0])));
  // R8
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_req_valid));
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_send && out_full) |=> (out_cnt == $past(out_cnt)));
  // R9
  park_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && out_empty) |=> (out_head == $past(bus_wdata)));
endmodule

// File: tb/sim_chan_mbox_ctrl.sv
module sim_chan_mbox_ctrl;
  localparam int NCH = 9;
  localparam int DEPTH = 8;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic bus_ready;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, chan_req_data;
  logic irq_o;
  logic [NCH-1:0] chan_avail = '0, chan_busy = '0, chan_take, chan_req_valid;
  logic [NCH*32-1:0] chan_rdata = '0;

  always #4 clk = ~clk;

  chan_mbox_ctrl #(.NCH(NCH), .DEPTH(DEPTH), .ADDR_W(AW)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  string rtag = "";
  logic [31:0] inq[$];
  logic [31:0] chq[NCH][$];
  int ob_cnt = 0;
  logic en = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input int cnt);
    return {cnt == DEPTH, cnt == 0, 22'd0, 8'(cnt)};
  endfunction

  task automatic cyc(input logic v, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    logic [7:0] o;
    logic [31:0] er;
    logic [NCH-1:0] etake, evalid;
    string t;
    int c;
    bit ispop, issend;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    for (int i = 0; i < NCH; i++) begin
      chan_avail[i] = chq[i].size() > 0;
      chan_rdata[32*i +: 32] = (chq[i].size() > 0) ? chq[i][0] : 32'h0;
    end
    #1;
    o = a[7:0];
    ispop  = (o >= 8'h80 && o <= 8'h8C);
    issend = (o >= 8'hA0 && o <= 8'hAC);
    // R6 interrupt level
    chk((rtag != "") ? rtag : "R6", 32'(irq_o), 32'(en && inq.size() > 0));
    // R10 collection choice
    etake = '0;
    if (inq.size() < DEPTH)
      for (int i = 0; i < NCH; i++)
        if (etake == '0 && chq[i].size() > 0) etake[i] = 1'b1;
    chk("R10", 32'(chan_take), 32'(etake));
    // R7 R8 R9 dispatch
    evalid = '0;
    c = int'(d[3:0]);
    if (v && w && issend && ob_cnt < DEPTH && c < NCH && !chan_busy[c]) evalid[c] = 1'b1;
    chk("R7/R8", 32'(chan_req_valid), 32'(evalid));
    if (evalid != '0) chk("R8", chan_req_data, d);
    if (v && !w) begin
      er = 32'h0; t = "R11";
      if (ispop || o == 8'h90) begin
        er = (inq.size() > 0) ? inq[0] : 32'hFFFF_FFFF; t = ispop ? "R2" : "R3";
      end else if (o == 8'h98) begin er = sw(inq.size()); t = "R4"; end
      else if (o == 8'hB8) begin er = sw(ob_cnt); t = "R4/R9"; end
      else if (o == 8'h9C) begin er = {27'd0, inq.size() > 0, 3'd0, en}; t = "R5"; end
      if (rtag != "") t = rtag;
      chk(t, bus_rdata, er);
    end
    @(posedge clk);
    if (v && !w && ispop && inq.size() > 0) void'(inq.pop_front());
    for (int i = 0; i < NCH; i++)
      if (etake[i]) inq.push_back(chq[i].pop_front());
    if (v && w && issend && ob_cnt < DEPTH && c < NCH && chan_busy[c]) ob_cnt++;
    if (v && w && o == 8'h9C) en = d[0];
    @(negedge clk);
  endtask

  task automatic rdr(input logic [AW-1:0] a); cyc(1'b1, 1'b0, a, 32'h0); endtask
  task automatic wrr(input logic [AW-1:0] a, input logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 32'h0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rtag = "R1";
    rdr(12'h098); rdr(12'h0B8); rdr(12'h09C); rdr(12'h080); idle(1);
    rtag = "";
    rdr(12'h090);
    // R10 ordering across channels
    chq[3].push_back(32'hA000_0001); chq[3].push_back(32'hA000_0002);
    chq[1].push_back(32'hB000_0001); chq[8].push_back(32'hC000_0001);
    idle(6);
    rdr(12'h09C);
    // R5 only bit 0 is written
    wrr(12'h09C, 32'hFFFF_FFF1); rdr(12'h09C); rdr(12'h098);
    rdr(12'h090); rdr(12'h090);
    for (int i = 0; i < 5; i++) rdr(12'h084 + AW'(4 * (i % 4)));
    wrr(12'h39C, 32'h0);                // R4 upper address bits ignored
    rdr(12'h09C);
    // R10 stall on full inbound queue
    for (int i = 0; i < 11; i++) chq[0].push_back(32'hD000_0000 + 32'(i));
    chq[2].push_back(32'hE000_0000);
    idle(12); rdr(12'h198);
    wrr(12'h09C, 32'h1);
    for (int i = 0; i < 14; i++) rdr(12'h080);
    idle(2);
    // R8 forward to idle channel, R7 bad channel
    wrr(12'h0A0, 32'h1234_5672); wrr(12'h0AC, 32'h0000_0008);
    wrr(12'h0A4, 32'h0000_0009); wrr(12'h0A8, 32'hFFFF_FFFF);
    // R9 busy channel parks words until the outbound queue is full
    chan_busy = 9'h020;
    for (int i = 0; i < DEPTH + 1; i++) wrr(12'h0A0, 32'h5500_0005 + 32'(i << 4));
    rdr(12'h0B8);
    wrr(12'h0A0, 32'h0000_0002);        // R7 full drops even idle channel
    rdr(12'h0B8);
    // R11 unsupported offsets
    wrr(12'h094, 32'h1); wrr(12'h0C0, 32'hFFFF_FFFF); wrr(12'h098, 32'h0);
    rdr(12'h094); rdr(12'h0C0); rdr(12'h1A0); rdr(12'h09C); rdr(12'h098);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule